// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Unit

This block is the interrupt front end of a small 8-bit processor. It watches five request lines. One line is a critical request that cannot be masked. One line is latched on its rising edge. Two lines are level sensitive. The last line is an external request that carries no vector. The block applies a per-line trigger rule, three mask bits and a global enable. It then picks one winner by fixed priority.

Toward the processor core, the block reports four things: whether an interrupt is pending, which source won, whether a vector address is supplied, and that 16-bit address. The address is the restart number times eight. The critical line counts as restart 4.5. An acknowledge pulse clears the latch of the winning source and drops the global enable. A small configuration write port loads the masks and can flush the edge latch. A status word reads back the masks, the enable and the raw pending state.

Top module: `irq_prio_unit`

## Requirements
- R1: When several sources are active, `src_o` names only the highest one. The order from highest to lowest is critical (code 5), edge line (4), mid level line (3), low level line (2), external (1). Code 0 means nothing is pending, and in that case `pend_o` is 0.
- R2: The critical source (`irq_i[4]`) is reported no matter what the masks and the global enable hold.
- R3: The critical source becomes active one clock after a rising edge of its line, and only while the line stays high. It drops as soon as the line goes low. After it is acknowledged, a line that stays high does not request again.
- R4: A rising edge on `irq_i[3]` sets a sticky latch. The latch survives the line falling. It clears on an acknowledge that this source wins, or on a configuration write with `cfg_wdata_i[4]`=1.
- R5: The mid (`irq_i[2]`) and low (`irq_i[1]`) sources follow their line levels in the same cycle, as does the external source (`irq_i[0]`). Dropping a line withdraws its request.
- R6: With `vec_valid_o`=1, `vec_o` is 0x0024 for the critical source, 0x003C for the edge line, 0x0034 for the mid line and 0x002C for the low line. For the external source, or when nothing is pending, `vec_valid_o`=0 and `vec_o`=0.
- R7: A configuration write with `cfg_wdata_i[3]`=1 loads the masks from `cfg_wdata_i[2:0]`: bit 0 is the low line, bit 1 the mid line, bit 2 the edge line, and 1 blocks the source. With `cfg_wdata_i[3]`=0 the masks keep their value.
- R8: The global enable is set by `ie_set_i` and cleared by `ie_clr_i`. While it is 0, the edge, mid, low and external sources are blocked. An acknowledge while `pend_o`=1 clears the enable. An acknowledge while nothing is pending changes nothing.
- R9: `stat_o` holds the masks in [2:0], the global enable in [3], the low line level in [4], the mid line level in [5] and the edge latch in [6]. Bit [7] is 0.
- R10: After reset the masks are 3'b111, the enable is 0, both latches are clear and `pend_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 5 | Request lines: [4] critical, [3] edge, [2] mid, [1] low, [0] external |
| ie_set_i | input | 1 | Set the global enable |
| ie_clr_i | input | 1 | Clear the global enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | [2:0] masks, [3] apply masks, [4] flush edge latch |
| ack_i | input | 1 | Acknowledge of the current winner |
| pend_o | output | 1 | An interrupt is pending |
| src_o | output | 3 | Winning source code |
| vec_valid_o | output | 1 | `vec_o` holds a service address |
| vec_o | output | 16 | Service address |
| stat_o | output | 8 | Status readback |

## Verification
A table of level-line patterns is walked under varied masks and enable settings. All-high inputs separate the priority order, and partial mask sets show that masking one source exposes the next one down. Enable-off rows show that the gate blocks every maskable line at once. Directed sequences then hold the critical line high across an acknowledge, which separates edge acceptance from plain level sensing. They also pulse the edge line for a single cycle, which separates a sticky latch from a level input. A stacked case with every source active is then acknowledged step by step, so that each source is shown to emerge in turn, together with its vector.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = 3;
  localparam int VEC_W   = 16;
  localparam int CFG_W   = 5;
  localparam int STAT_W  = 8;

  localparam int IDX_EXT  = 0;
  localparam int IDX_LO   = 1;
  localparam int IDX_MID  = 2;
  localparam int IDX_HI   = 3;
  localparam int IDX_CRIT = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_EXT  = 3'd1,
    SRC_LO   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_HI   = 3'd4,
    SRC_CRIT = 3'd5
  } src_e;

  // Restart number doubled, so that the half step of the critical line stays an integer.
  function automatic logic [4:0] twice_restart(input logic [SRC_W-1:0] code);
    case (code)
      SRC_CRIT: return 5'd9;
      SRC_HI:   return 5'd15;
      SRC_MID:  return 5'd13;
      SRC_LO:   return 5'd11;
      default:  return 5'd0;
    endcase
  endfunction

  // address = n * 8 = (2n) * 4
  function automatic logic [VEC_W-1:0] restart_addr(input logic [4:0] two_n);
    return VEC_W'(two_n) << 2;
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic crit_line_i,
  input  logic hi_line_i,
  input  logic crit_ack_i,
  input  logic hi_ack_i,
  input  logic hi_flush_i,
  output logic crit_act_o,
  output logic hi_lat_o
);
  logic prev_crit_q, prev_hi_q, crit_lat_q, hi_lat_q;
  logic crit_rise, hi_rise;

  assign crit_rise = crit_line_i & ~prev_crit_q;
  assign hi_rise   = hi_line_i & ~prev_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_crit_q <= 1'b0;
      prev_hi_q   <= 1'b0;
      crit_lat_q  <= 1'b0;
      hi_lat_q    <= 1'b0;
    end else begin
      prev_crit_q <= crit_line_i;
      prev_hi_q   <= hi_line_i;
      crit_lat_q  <= crit_rise | (crit_lat_q & crit_line_i & ~crit_ack_i);
      hi_lat_q    <= hi_rise | (hi_lat_q & ~(hi_ack_i | hi_flush_i));
    end
  end

  assign crit_act_o = crit_lat_q & crit_line_i;
  assign hi_lat_o   = hi_lat_q;

  a_r3_low_line_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_line_i |=> !crit_lat_q);
  a_r3_ack_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    crit_ack_i |=> !crit_lat_q);
  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hi_lat_q && !hi_ack_i && !hi_flush_i |=> hi_lat_q);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             ack_take_i,
  output logic [2:0]       mask_o,
  output logic             ie_o
);
  localparam int APPLY_BIT = 3;

  logic       mask_load;
  logic [2:0] mask_q;
  logic       ie_q;

  assign mask_load = cfg_wr_i & cfg_wdata_i[APPLY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 3'b111;
      ie_q   <= 1'b0;
    end else begin
      if (mask_load) mask_q <= cfg_wdata_i[2:0];
      if (ack_take_i || ie_clr_i) ie_q <= 1'b0;
      else if (ie_set_i)          ie_q <= 1'b1;
    end
  end

  assign mask_o = mask_q;
  assign ie_o   = ie_q;

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_i && cfg_wdata_i[APPLY_BIT]) |=> $stable(mask_o));
  a_r8_ack_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take_i |=> !ie_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     act_i,
  output logic [N-1:0]     grant_o,
  output logic             pend_o,
  output logic [SRC_W-1:0] src_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N:0] above;
  assign above[N] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant_o[i] = act_i[i] & ~above[i+1];
    assign above[i]   = above[i+1] | act_i[i];
  end

  assign pend_o = above[0];

  always_comb begin
    src_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) src_o = SRC_W'(i + 1);
  end

  assign vec_valid_o = (twice_restart(src_o) != 5'd0);
  assign vec_o       = restart_addr(twice_restart(src_o));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam int FLUSH_BIT = 4;

  logic [NUM_SRC-1:0] act, grant;
  logic [2:0]         mask;
  logic               ie, crit_act, hi_lat, ack_take;

  assign ack_take = ack_i & pend_o;

  irq_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .crit_line_i (irq_i[IDX_CRIT]),
    .hi_line_i   (irq_i[IDX_HI]),
    .crit_ack_i  (ack_i & grant[IDX_CRIT]),
    .hi_ack_i    (ack_i & grant[IDX_HI]),
    .hi_flush_i  (cfg_wr_i & cfg_wdata_i[FLUSH_BIT]),
    .crit_act_o  (crit_act),
    .hi_lat_o    (hi_lat)
  );

  irq_ctrl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .ie_set_i    (ie_set_i),
    .ie_clr_i    (ie_clr_i),
    .ack_take_i  (ack_take),
    .mask_o      (mask),
    .ie_o        (ie)
  );

  assign act[IDX_CRIT] = crit_act;
  assign act[IDX_HI]   = hi_lat & ~mask[2] & ie;
  assign act[IDX_MID]  = irq_i[IDX_MID] & ~mask[1] & ie;
  assign act[IDX_LO]   = irq_i[IDX_LO] & ~mask[0] & ie;
  assign act[IDX_EXT]  = irq_i[IDX_EXT] & ie;

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .act_i       (act),
    .grant_o     (grant),
    .pend_o      (pend_o),
    .src_o       (src_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );

  assign stat_o = {1'b0, hi_lat, irq_i[IDX_MID], irq_i[IDX_LO], ie, mask};

  a_r1_crit_first: assert property (@(posedge clk) disable iff (!rst_n)
    crit_act |-> src_o == SRC_CRIT);
  a_r1_edge_over_levels: assert property (@(posedge clk) disable iff (!rst_n)
    act[IDX_HI] && !crit_act |-> src_o == SRC_HI);
  a_r2_crit_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    crit_act && !ie |-> pend_o);
  a_r6_ext_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
    src_o == SRC_EXT |-> !vec_valid_o && vec_o == '0);
endmodule

// File: tb/irq_prio_unit_tb_top.sv
module irq_prio_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq_i = '0;
  logic        ie_set_i = 1'b0, ie_clr_i = 1'b0, cfg_wr_i = 1'b0, ack_i = 1'b0;
  logic [4:0]  cfg_wdata_i = '0;
  logic        pend_o, vec_valid_o;
  logic [2:0]  src_o;
  logic [15:0] vec_o;
  logic [7:0]  stat_o;

  int unsigned n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ie_set_i(ie_set_i),
    .ie_clr_i(ie_clr_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .ack_i(ack_i), .pend_o(pend_o), .src_o(src_o), .vec_valid_o(vec_valid_o),
    .vec_o(vec_o), .stat_o(stat_o)
  );

  // {ie, mask[2:0], lines mid/lo/ext, expected source code}
  localparam logic [9:0] TBL [8] = '{
    {1'b1, 3'b000, 3'b111, 3'd3},
    {1'b1, 3'b010, 3'b111, 3'd2},
    {1'b1, 3'b011, 3'b111, 3'd1},
    {1'b0, 3'b000, 3'b111, 3'd0},
    {1'b1, 3'b000, 3'b011, 3'd2},
    {1'b1, 3'b000, 3'b001, 3'd1},
    {1'b1, 3'b111, 3'b110, 3'd0},
    {1'b1, 3'b001, 3'b100, 3'd3}
  };

  function automatic logic [15:0] exp_vec(input logic [2:0] code);
    case (code)
      3'd5: return 16'h0024;
      3'd4: return 16'h003C;
      3'd3: return 16'h0034;
      3'd2: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_src(input string req, input logic [2:0] code);
    check(req, {28'd0, pend_o, src_o}, {28'd0, code != 3'd0, code});
    check(req, {15'd0, vec_valid_o, vec_o}, {15'd0, (code >= 3'd2), exp_vec(code)});
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic cfg_write(input logic [4:0] d);
    cfg_wr_i = 1'b1; cfg_wdata_i = d;
    tick();
    cfg_wr_i = 1'b0; cfg_wdata_i = '0;
  endtask

  task automatic set_ie(input logic on);
    ie_set_i = on; ie_clr_i = ~on;
    tick();
    ie_set_i = 1'b0; ie_clr_i = 1'b0;
  endtask

  task automatic ack_pulse;
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    check("R10 pend", {31'd0, pend_o}, 32'd0);
    check("R10 stat", {24'd0, stat_o}, 32'h07);

    // R7 write without apply bit keeps masks
    cfg_write(5'b00000);
    check("R7 no apply", {29'd0, stat_o[2:0]}, 32'd7);

    // table walk: R1 R5 R6 R7 R8
    for (int k = 0; k < 8; k++) begin
      cfg_wr_i = 1'b1; cfg_wdata_i = {2'b01, TBL[k][8:6]};
      ie_set_i = TBL[k][9]; ie_clr_i = ~TBL[k][9];
      tick();
      cfg_wr_i = 1'b0; cfg_wdata_i = '0; ie_set_i = 1'b0; ie_clr_i = 1'b0;
      irq_i = {2'b00, TBL[k][5:3]};
      #1;
      check_src($sformatf("R1/R5/R6/R7/R8 row %0d", k), TBL[k][2:0]);
      irq_i = '0;
    end

    // R2 R3 critical line, masks all set, enable off
    cfg_write(5'b01111);
    set_ie(1'b0);
    irq_i[4] = 1'b1; #1;
    check("R3 not before edge capture", {31'd0, pend_o}, 32'd0);
    tick();
    check_src("R2 crit ignores mask and enable", 3'd5);
    irq_i[4] = 1'b0; #1;
    check("R3 drop on low", {31'd0, pend_o}, 32'd0);
    tick();
    irq_i[4] = 1'b1;
    tick();
    check_src("R3 crit again", 3'd5);
    ack_pulse();
    check("R3 no rearm after ack", {31'd0, pend_o}, 32'd0);
    tick();
    check("R3 still quiet", {31'd0, pend_o}, 32'd0);
    irq_i[4] = 1'b0;

    // R4 edge latch
    cfg_write(5'b01000);
    set_ie(1'b1);
    irq_i[3] = 1'b1;
    tick();
    irq_i[3] = 1'b0; #1;
    check_src("R4 latched after line falls", 3'd4);
    check("R9 edge latch bit", {31'd0, stat_o[6]}, 32'd1);
    tick();
    check_src("R4 sticky", 3'd4);
    cfg_write(5'b10000);
    check("R4 flush clears", {31'd0, pend_o}, 32'd0);
    check("R7 flush keeps masks", {29'd0, stat_o[2:0]}, 32'd0);

    // R1 stacked sources, peeled by acknowledges
    irq_i = 5'b01111;
    tick();
    irq_i = 5'b00111; #1;
    check_src("R1 edge over levels", 3'd4);
    irq_i = 5'b10111;
    tick();
    check_src("R1 crit on top", 3'd5);
    ack_pulse();
    check("R8 ack clears enable", {31'd0, stat_o[3]}, 32'd0);
    check("R8 all maskable blocked", {31'd0, pend_o}, 32'd0);
    set_ie(1'b1);
    check_src("R1 edge next", 3'd4);
    check("R9 raw levels", {30'd0, stat_o[5:4]}, 32'd3);
    ack_pulse();
    set_ie(1'b1);
    check_src("R4 ack cleared latch, mid next", 3'd3);
    irq_i = 5'b10011; #1;
    check_src("R5 mid withdrawn", 3'd2);
    irq_i = 5'b10001; #1;
    check_src("R6 external no vector", 3'd1);
    irq_i = 5'b00000; #1;
    check_src("R1 none", 3'd0);

    // R8 ack while idle
    ack_pulse();
    check("R8 idle ack keeps enable", {31'd0, stat_o[3]}, 32'd1);

    // R9 status with a masked line
    cfg_write(5'b01101);
    irq_i = 5'b00110; #1;
    check("R9 status word", {24'd0, stat_o}, 32'h3D);
    check_src("R7 low masked, mid wins", 3'd3);
    irq_i = '0;

    done = 1'b1;
    summary();
  end
endmodule